// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

Two eight-line priority interrupt controllers share one interrupt output to the CPU. The primary bank serves request lines 0 to 7. The secondary bank serves lines 8 to 15, and its own pending state drives input 2 of the primary bank. Requests are caught on rising edges.

A small register port selects a bank and writes one of four things to it: the mask, the vector base, a non-specific end-of-interrupt, or the rotating priority offset. When the CPU pulses `ack`, the block does four things:

- It resolves the winning line.
- It moves that line from pending to in-service.
- It returns an 8-bit vector one cycle later.
- It re-evaluates the interrupt output.

When nothing can be resolved, the block returns the line-7 vector of the bank concerned.

The block sits between the peripheral interrupt lines and one CPU interrupt pin. Software programs masks and bases once. For each delivered interrupt it issues one end-of-interrupt to the bank that served it. A cascaded interrupt needs one end-of-interrupt to each bank.

Top module: `dual_irq_ctrl`

## Requirements
- R1: A request is latched when its `req_in` line shows a rising edge. A line held high after its acknowledge does not raise a new request.
- R2: `req_in[2]` has no effect. Primary input 2 is driven only by the secondary bank.
- R3: A line whose mask bit is 1 never wins resolution and never raises `cpu_irq`. The mask write encoding is `wr_op`=0, with `wr_data[i]` masking line i. After reset all lines are masked.
- R4: `cpu_irq` is a register. It is 1 exactly one cycle after the primary bank holds a resolvable request, and 0 one cycle after it holds none.
- R5: Each bank ranks line i as (i − offset) mod 8, and rank 0 is the highest priority. The offset resets to 0 and is written with `wr_op`=3 from `wr_data[2:0]`.
- R6: A pending line is resolvable only if it ranks higher than every in-service line of its bank. Acknowledging a line clears its pending bit and sets its in-service bit.
- R7: `vec_valid` pulses for exactly the cycle after an `ack` cycle. For a primary line L other than 2, `vec_out` = {base[7:3], L}. The base is written with `wr_op`=1 from `wr_data[7:3]` and resets to 0x08 (primary) and 0x70 (secondary).
- R8: When the secondary bank holds a resolvable request, primary line 2 becomes pending. Acknowledging it returns {secondary base, secondary line} and marks both banks in service.
- R9: An `ack` while the primary bank has nothing resolvable returns {primary base, 7} and changes no in-service state.
- R10: If primary line 2 wins but the secondary bank has nothing resolvable, the vector is {secondary base, 7}. This happens, for example, when the secondary request was masked in the cycle before `ack`.
- R11: Primary line 2 is cleared one cycle after the secondary bank loses its resolvable request, so lower-priority primary lines are still delivered.
- R12: An end-of-interrupt (`wr_op`=2, bank chosen by `wr_sel`: 0 primary, 1 secondary) clears only the highest-ranked in-service bit of that bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 16 | Request lines; [7:0] primary, [15:8] secondary |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Bank select: 0 primary, 1 secondary |
| wr_op | input | 2 | 0 mask, 1 base, 2 end-of-interrupt, 3 priority offset |
| wr_data | input | 8 | Write data |
| ack | input | 1 | Interrupt acknowledge strobe |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |
| vec_valid | output | 1 | Vector valid, one cycle after ack |
| vec_out | output | 8 | Interrupt vector |

## Verification
The bench attacks the one-cycle window in which primary line 2 is still latched after the secondary request has been masked. A design that skipped the secondary spurious path would return a stale secondary line or a primary vector instead of the secondary line-7 vector. It also checks that line 2 drops afterwards. A design that left line 2 stuck would keep `cpu_irq` high and hide primary line 5 behind the cascade. Nested priority with a rotated offset and end-of-interrupt ordering are driven as well. A design that cleared the wrong in-service bit, or ranked from line 0 regardless of offset, would deliver lines out of order. Throughout, a behavioural model recomputes `cpu_irq` and every vector on each clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Register port operation codes.
  typedef enum logic [1:0] {
    OP_MASK = 2'd0,
    OP_BASE = 2'd1,
    OP_EOI  = 2'd2,
    OP_ROT  = 2'd3
  } irq_op_e;
endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/irq_prio_pick.sv
// Rotating-priority resolver: rank of line i is (i - offs) mod N, rank 0 wins.
module irq_prio_pick #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  isr,
  input  logic [LW-1:0] offs,
  output logic          pick_valid,
  output logic [LW-1:0] pick_line,
  output logic          top_any,
  output logic [LW-1:0] top_line
);
  logic [N-1:0]  rpend, risr;
  logic          p_hit, i_hit;
  logic [LW-1:0] p_rank, i_rank;

  // Rotate both vectors into rank order.
  always_comb begin
    rpend = '0;
    risr  = '0;
    for (int r = 0; r < N; r++) begin
      rpend[r] = pend[LW'(r) + offs];
      risr[r]  = isr[LW'(r) + offs];
    end
  end

  // Lowest rank set wins.
  always_comb begin
    p_hit  = 1'b0;
    p_rank = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (rpend[r]) begin
        p_hit  = 1'b1;
        p_rank = LW'(r);
      end
    end
  end

  always_comb begin
    i_hit  = 1'b0;
    i_rank = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (risr[r]) begin
        i_hit  = 1'b1;
        i_rank = LW'(r);
      end
    end
  end

  assign pick_valid = p_hit && (!i_hit || (p_rank < i_rank));
  assign pick_line  = p_rank + offs;
  assign top_any    = i_hit;
  assign top_line   = i_rank + offs;
endmodule

// File: rtl/irq_bank.sv
module irq_bank import irq_pkg::*; #(
  parameter int            N          = 8,
  parameter int            VW         = 8,
  parameter logic [N-1:0]  LEVEL_MASK = '0,
  parameter logic [VW-1:0] BASE_RST   = 8'h08,
  localparam int           LW         = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     line_in,
  input  logic             wr_en,
  input  irq_op_e          wr_op,
  input  logic [VW-1:0]    wr_data,
  input  logic             ack_en,
  output logic             pick_valid,
  output logic [LW-1:0]    pick_line,
  output logic [VW-LW-1:0] base_q
);
  logic [N-1:0]  irr, imr, isr;
  logic [N-1:0]  irr_nx, ack_mask, eoi_mask;
  logic [LW-1:0] offs;
  logic          top_any;
  logic [LW-1:0] top_line;
  logic          ack_hit, eoi_go;

  irq_prio_pick #(.N(N)) u_pick (
    .pend       (irr & ~imr),
    .isr        (isr),
    .offs       (offs),
    .pick_valid (pick_valid),
    .pick_line  (pick_line),
    .top_any    (top_any),
    .top_line   (top_line)
  );

  assign ack_hit = ack_en && pick_valid;
  assign eoi_go  = wr_en && (wr_op == OP_EOI) && top_any;

  always_comb begin
    ack_mask = '0;
    eoi_mask = '0;
    if (ack_hit) ack_mask[pick_line] = 1'b1;
    if (eoi_go)  eoi_mask[top_line]  = 1'b1;
  end

  // Level lines follow their input (cleared by ack); edge lines latch.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (LEVEL_MASK[i]) irr_nx[i] = ack_mask[i] ? 1'b0 : line_in[i];
      else               irr_nx[i] = (irr[i] & ~ack_mask[i]) | line_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr    <= '0;
      isr    <= '0;
      imr    <= '1;
      offs   <= '0;
      base_q <= BASE_RST[VW-1:LW];
    end else begin
      irr <= irr_nx;
      isr <= (isr & ~eoi_mask) | ack_mask;
      if (wr_en) begin
        case (wr_op)
          OP_MASK: imr    <= wr_data[N-1:0];
          OP_BASE: base_q <= wr_data[VW-1:LW];
          OP_ROT:  offs   <= wr_data[LW-1:0];
          default: ;
        endcase
      end
    end
  end

  // R3: resolver never selects a masked line
  p_pick_unmasked_r3: assert property (@(posedge clk) disable iff (rst)
    pick_valid |-> !imr[pick_line]);

  // R6: an acknowledged line is in service on the next cycle
  p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (rst)
    ack_hit |=> isr[$past(pick_line)]);

  // R12: a lone end-of-interrupt removes exactly one in-service bit
  p_eoi_single_r12: assert property (@(posedge clk) disable iff (rst)
    (eoi_go && !ack_hit) |=> ($countones(isr) == $past($countones(isr)) - 1));
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl import irq_pkg::*; #(
  parameter int            LINES        = 8,
  parameter int            VW           = 8,
  parameter int            CASC_LINE    = 2,
  parameter logic [VW-1:0] PRI_BASE_RST = 8'h08,
  parameter logic [VW-1:0] SEC_BASE_RST = 8'h70
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*LINES-1:0] req_in,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [1:0]         wr_op,
  input  logic [VW-1:0]      wr_data,
  input  logic               ack,
  output logic               cpu_irq,
  output logic               vec_valid,
  output logic [VW-1:0]      vec_out
);
  localparam int             LW   = $clog2(LINES);
  localparam logic [LW-1:0]  SPUR = '1;
  localparam logic [LW-1:0]  CL   = LW'(CASC_LINE);
  localparam logic [LINES-1:0] LVL0 = LINES'(1) << CASC_LINE;

  logic [2*LINES-1:0] rise;
  logic [LINES-1:0]   bank_in [2];
  logic               bank_ack[2];
  logic               pv      [2];
  logic [LW-1:0]      pl      [2];
  logic [VW-LW-1:0]   bq      [2];

  irq_rise_det #(.W(2*LINES)) u_rise (
    .clk  (clk),
    .rst  (rst),
    .lvl  (req_in),
    .rise (rise)
  );

  // Primary cascade input is driven by the secondary resolver, not a pin.
  always_comb begin
    bank_in[0]     = rise[LINES-1:0];
    bank_in[0][CL] = pv[1];
    bank_in[1]     = rise[2*LINES-1:LINES];
  end

  assign bank_ack[0] = ack;
  assign bank_ack[1] = ack && pv[0] && (pl[0] == CL);

  for (genvar g = 0; g < 2; g++) begin : g_bank
    irq_bank #(
      .N          (LINES),
      .VW         (VW),
      .LEVEL_MASK ((g == 0) ? LVL0 : '0),
      .BASE_RST   ((g == 0) ? PRI_BASE_RST : SEC_BASE_RST)
    ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .line_in    (bank_in[g]),
      .wr_en      (wr_en && (wr_sel == 1'(g))),
      .wr_op      (irq_op_e'(wr_op)),
      .wr_data    (wr_data),
      .ack_en     (bank_ack[g]),
      .pick_valid (pv[g]),
      .pick_line  (pl[g]),
      .base_q     (bq[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      cpu_irq   <= pv[0];
      vec_valid <= ack;
      if (ack) begin
        if (!pv[0])         vec_out <= {bq[0], SPUR};
        else if (pl[0] != CL) vec_out <= {bq[0], pl[0]};
        else if (pv[1])     vec_out <= {bq[1], pl[1]};
        else                vec_out <= {bq[1], SPUR};
      end
    end
  end

  // R7: vector valid is a one-cycle echo of ack
  p_vec_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ack |=> vec_valid);
  p_vec_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !ack |=> !vec_valid);

  // R9: nothing resolvable on the primary gives the line-7 code
  p_spur_pri_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && !pv[0]) |=> (vec_out[LW-1:0] == SPUR));

  // R10: cascade won but secondary empty gives secondary base plus 7
  p_spur_sec_r10: assert property (@(posedge clk) disable iff (rst)
    (ack && pv[0] && (pl[0] == CL) && !pv[1]) |=> (vec_out == {$past(bq[1]), SPUR}));

  // R11: primary cascade line cannot win once the secondary went idle
  p_casc_clear_r11: assert property (@(posedge clk) disable iff (rst)
    !pv[1] |=> !(pv[0] && (pl[0] == CL)));
endmodule

// File: tb/dual_irq_ctrl_test.sv
`timescale 1ns/1ps
module dual_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] req_in;
  logic        wr_en, wr_sel, ack;
  logic [1:0]  wr_op;
  logic [7:0]  wr_data;
  logic        cpu_irq, vec_valid;
  logic [7:0]  vec_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dual_irq_ctrl uut (
    .clk(clk), .rst(rst), .req_in(req_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_op(wr_op), .wr_data(wr_data), .ack(ack), .cpu_irq(cpu_irq),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_irr[2], m_imr[2], m_isr[2], m_base[2];
  int          m_offs[2];
  logic [15:0] m_reqq;
  logic        m_irq = 1'b0, m_vv = 1'b0;
  logic [7:0]  m_vec = 8'h00;

  function automatic void pick(input int c, output bit v, output int line,
                               output bit iany, output int iline);
    int pr = 8;
    int ir = 8;
    for (int r = 0; r < 8; r++) begin
      int l;
      l = (r + m_offs[c]) % 8;
      if (pr == 8 && m_irr[c][l] && !m_imr[c][l]) pr = r;
      if (ir == 8 && m_isr[c][l]) ir = r;
    end
    v     = (pr < 8) && (pr < ir);
    line  = (pr + m_offs[c]) % 8;
    iany  = (ir < 8);
    iline = (ir + m_offs[c]) % 8;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_irr[c] = 8'h00; m_isr[c] = 8'h00; m_imr[c] = 8'hFF; m_offs[c] = 0;
      end
      m_base[0] = 8'h08; m_base[1] = 8'h70;
      m_reqq = 16'h0; m_irq = 1'b0; m_vv = 1'b0; m_vec = 8'h00;
    end else begin
      bit v0, v1, a0, a1;
      int l0, l1, t0, t1;
      logic [15:0] rs;
      logic [7:0]  k0, k1, e0, e1, n0;
      pick(0, v0, l0, a0, t0);
      pick(1, v1, l1, a1, t1);
      rs = req_in & ~m_reqq;
      k0 = 8'h00; k1 = 8'h00; e0 = 8'h00; e1 = 8'h00;
      if (ack) begin
        if (!v0) m_vec = m_base[0] | 8'd7;
        else begin
          k0[l0] = 1'b1;
          if (l0 != 2) m_vec = m_base[0] | 8'(l0);
          else if (v1) begin k1[l1] = 1'b1; m_vec = m_base[1] | 8'(l1); end
          else m_vec = m_base[1] | 8'd7;
        end
      end
      if (wr_en && wr_op == 2'd2) begin
        if (!wr_sel && a0) e0[t0] = 1'b1;
        if (wr_sel && a1)  e1[t1] = 1'b1;
      end
      n0 = (m_irr[0] & ~k0) | rs[7:0];
      n0[2] = k0[2] ? 1'b0 : v1;
      m_irr[0] = n0;
      m_irr[1] = (m_irr[1] & ~k1) | rs[15:8];
      m_isr[0] = (m_isr[0] & ~e0) | k0;
      m_isr[1] = (m_isr[1] & ~e1) | k1;
      if (wr_en) begin
        case (wr_op)
          2'd0: m_imr[wr_sel]  = wr_data;
          2'd1: m_base[wr_sel] = wr_data & 8'hF8;
          2'd3: m_offs[wr_sel] = int'(wr_data[2:0]);
          default: ;
        endcase
      end
      m_irq = v0;
      m_vv  = ack;
      m_reqq = req_in;
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (cpu_irq !== m_irq) begin
        fails++;
        $display("FAIL R4 model cpu_irq act=%0b exp=%0b t=%0t", cpu_irq, m_irq, $time);
      end
      checks++;
      if (vec_valid !== m_vv) begin
        fails++;
        $display("FAIL R7 model vec_valid act=%0b exp=%0b t=%0t", vec_valid, m_vv, $time);
      end
      if (m_vv) begin
        checks++;
        if (vec_out !== m_vec) begin
          fails++;
          $display("FAIL R8 model vec_out act=%02h exp=%02h t=%0t", vec_out, m_vec, $time);
        end
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [1:0] op, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_op = op; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] m);
    req_in = req_in | m;
    @(negedge clk);
    req_in = req_in & ~m;
  endtask

  task automatic do_ack(input logic [7:0] exp, input string tag);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk({7'd0, vec_valid}, 8'd1, {tag, " vec_valid"});
    chk(vec_out, exp, tag);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; req_in = '0; wr_en = 0; wr_sel = 0; wr_op = 0; wr_data = 0; ack = 0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk({7'd0, cpu_irq}, 8'd0, "R4 reset cpu_irq");
    chk({7'd0, vec_valid}, 8'd0, "R7 reset vec_valid");
    // R3/R9: all masked at reset, ack is spurious with reset base
    pulse(16'h0010); cyc(3);
    chk({7'd0, cpu_irq}, 8'd0, "R3 masked at reset");
    do_ack(8'h0F, "R9 spurious primary reset base");
    wr(0, 2'd1, 8'h20); wr(1, 2'd1, 8'h28);
    wr(1, 2'd0, 8'h00);
    wr(0, 2'd0, 8'h10);                    // line 4 still masked
    cyc(3);
    chk({7'd0, cpu_irq}, 8'd0, "R3 masked pending line silent");
    wr(0, 2'd0, 8'h00); cyc(3);
    chk({7'd0, cpu_irq}, 8'd1, "R4 irq after unmask");
    do_ack(8'h24, "R7 line 4 vector");
    wr(0, 2'd2, 0); cyc(2);
    // R7 simple
    pulse(16'h0020); cyc(3);
    do_ack(8'h25, "R7 line 5 vector");
    wr(0, 2'd2, 0); cyc(2);
    // R1 held level
    req_in[3] = 1'b1; cyc(3);
    do_ack(8'h23, "R1 level line 3");
    wr(0, 2'd2, 0); cyc(3);
    chk({7'd0, cpu_irq}, 8'd0, "R1 held level no re-request");
    req_in[3] = 1'b0; cyc(2);
    // R2 cascade pin ignored
    pulse(16'h0004); cyc(3);
    chk({7'd0, cpu_irq}, 8'd0, "R2 req_in[2] ignored");
    // R5/R6/R12 nesting
    pulse(16'h0042); cyc(3);
    do_ack(8'h21, "R5 line 1 beats 6");
    cyc(2);
    chk({7'd0, cpu_irq}, 8'd0, "R6 line 6 blocked by in-service 1");
    pulse(16'h0001); cyc(3);
    chk({7'd0, cpu_irq}, 8'd1, "R6 higher line 0 preempts");
    do_ack(8'h20, "R6 line 0 vector");
    wr(0, 2'd2, 0); cyc(3);
    chk({7'd0, cpu_irq}, 8'd0, "R12 eoi cleared 0 only, 6 still blocked");
    wr(0, 2'd2, 0); cyc(3);
    chk({7'd0, cpu_irq}, 8'd1, "R12 second eoi frees line 6");
    do_ack(8'h26, "R12 line 6 vector");
    wr(0, 2'd2, 0); cyc(2);
    // R5 rotated offset
    wr(0, 2'd3, 8'h05);
    pulse(16'h0048); cyc(3);
    do_ack(8'h26, "R5 offset 5 ranks 6 above 3");
    wr(0, 2'd2, 0);
    do_ack(8'h23, "R5 offset 5 then line 3");
    wr(0, 2'd2, 0); wr(0, 2'd3, 8'h00); cyc(2);
    // R8 cascade
    pulse(16'h0800); cyc(4);
    chk({7'd0, cpu_irq}, 8'd1, "R8 secondary raises cpu_irq");
    do_ack(8'h2B, "R8 secondary line 3 vector");
    wr(1, 2'd2, 0); wr(0, 2'd2, 0); cyc(3);
    chk({7'd0, cpu_irq}, 8'd0, "R8 idle after both eoi");
    // R10 secondary spurious
    pulse(16'h0200); cyc(4);
    wr(1, 2'd0, 8'h02);
    do_ack(8'h2F, "R10 secondary spurious");
    wr(0, 2'd2, 0);
    wr(1, 2'd0, 8'h00); cyc(4);
    do_ack(8'h29, "R10 secondary line 1 after unmask");
    wr(1, 2'd2, 0); wr(0, 2'd2, 0); cyc(2);
    // R11 cascade line clears, lower line served
    pulse(16'h0200); cyc(4);
    wr(1, 2'd0, 8'h02); cyc(3);
    chk({7'd0, cpu_irq}, 8'd0, "R11 cascade line dropped");
    pulse(16'h0020); cyc(3);
    do_ack(8'h25, "R11 lower line 5 delivered");
    wr(0, 2'd2, 0);
    wr(1, 2'd0, 8'h00); cyc(4);
    do_ack(8'h29, "R11 secondary served after unmask");
    wr(1, 2'd2, 0); wr(0, 2'd2, 0); cyc(3);
    // R9 spurious with programmed base
    do_ack(8'h27, "R9 spurious primary");
    cyc(3);
    chk({7'd0, cpu_irq}, 8'd0, "R9 no in-service change");
    summary();
    $finish;
  end
endmodule